// File: doc/BRIEF.md
# Three-Channel Request Scheduler and Logical-to-Physical Address Translator

This block sits in front of the SDRAM command queue of a video decoder. Three requesters share it. The motion-compensation unit reads pixels, the deblocking filter writes pixels, and the direct-mode predictor reads co-located motion vectors. Each requester raises a valid and holds a logical address until it sees its acknowledge. Each pixel requester also holds a two-bit reference-frame index. The block grants one requester per cycle. The grant goes by fixed priority unless an anti-starvation override applies. The block then turns the winner's logical address into a bank, row and column tuple and places a request word in an output register. The downstream queue drains that register under valid/ready.

Motion vectors occupy the lowest partition of the physical space. Pixel frames follow it, each at a power-of-two stride chosen by the frame index. The request word carries a write flag that is set only for deblocking traffic. The flag is followed by the row, bank and column fields. The command queue decodes these fields by position.

Top module: `chan_addr_xlate`

## Requirements
- R1: While reset is asserted, and with no request pending after it, `outValid` is 0 and all three acknowledges are 0.
- R2: When no channel is starved, a grant goes to motion compensation (channel 0) first, then deblocking (channel 1), then the motion-vector reader (channel 2).
- R3: A channel that is valid and has lost 8 consecutive accepted grants is starved and wins the next grant. Among several starved channels the lowest-priority one wins. Granting a channel, or the channel dropping its valid, clears its loss count.
- R4: A request is accepted in a cycle when some channel is valid and the output register is empty or being drained (`outValid && outReady`). In that cycle exactly the winning channel's acknowledge is high. At most one acknowledge is high in any cycle.
- R5: While `outValid` is 1 and `outReady` is 0, no acknowledge is raised and `outWord` does not change.
- R6: A motion-vector request's physical linear address equals its 16-bit logical address, so it always lies below 2^16, the first partition.
- R7: A pixel request's physical linear address equals 2^16 + frame × 2^19 + logical address. The logical address is 19 bits and the frame index is 2 bits.
- R8: `outWord` bit 22 is the write flag and is 1 only for deblocking requests. Bits 21:10 are the row, bits 9:8 the bank and bits 7:0 the column of the linear address. Row is the linear address bits 21:10, bank bits 9:8 and column bits 7:0.
- R9: A request accepted in cycle t is presented on `outWord` with `outValid` high from cycle t+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mcValid | input | 1 | Motion-compensation read request pending |
| mcAddr | input | 19 | Motion-compensation pixel logical address |
| mcFrame | input | 2 | Motion-compensation reference frame index |
| mcAck | output | 1 | Motion-compensation request accepted this cycle |
| dbValid | input | 1 | Deblocking write request pending |
| dbAddr | input | 19 | Deblocking pixel logical address |
| dbFrame | input | 2 | Deblocking target frame index |
| dbAck | output | 1 | Deblocking request accepted this cycle |
| mvValid | input | 1 | Motion-vector read request pending |
| mvAddr | input | 16 | Motion-vector logical address |
| mvAck | output | 1 | Motion-vector request accepted this cycle |
| outValid | output | 1 | Request word held for the command queue |
| outReady | input | 1 | Command queue takes the word this cycle |
| outWord | output | 23 | Write flag, row, bank, column |

## Verification
A corrupted loss counter shows at the acknowledge outputs. It either moves the starvation override away from the ninth lost grant or lets a lower channel win early, so it appears within one arbitration round of eight grants. A wrong output-register state shows on the next cycle. Either `outValid` disagrees with the accept/drain history, or a stalled word changes, or a word is dropped. A translation fault shows on the first accepted request that uses the bad field, partition or frame stride. The bench compares every request word against an independent model as it is presented.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int NUM_CH     = 3;
  localparam int CH_MC      = 0;
  localparam int CH_DB      = 1;
  localparam int CH_MV      = 2;
  localparam int COL_W      = 8;
  localparam int BANK_W     = 2;
  localparam int ROW_W      = 12;
  localparam int MV_W       = 16;
  localparam int PIX_W      = 19;
  localparam int FRM_W      = 2;
  localparam int STARVE_LIM = 8;

  // Strobes from arbitration control to the translation datapath
  typedef struct packed {
    logic              load;
    logic [NUM_CH-1:0] sel;
  } xlStrobe_t;
endpackage

// File: rtl/xl_arb_ctrl.sv
module xl_arb_ctrl
  import xl_pkg::*;
#(
  parameter int LIMIT = STARVE_LIM
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqValid,
  input  logic              outReady,
  output xlStrobe_t         strobes,
  output logic [NUM_CH-1:0] ack,
  output logic              outValid
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0]  lossCnt [NUM_CH];
  logic [NUM_CH-1:0] starved;
  logic [NUM_CH-1:0] winSel;
  logic              outValidReg;
  logic              loadNow;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_starve
      assign starved[g] = reqValid[g] && (lossCnt[g] >= CNT_W'(LIMIT));
    end
  endgenerate

  always_comb begin
    logic found;
    found  = 1'b0;
    winSel = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (!found && starved[i]) begin
        winSel[i] = 1'b1;
        found     = 1'b1;
      end
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && reqValid[i]) begin
        winSel[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign loadNow     = (|reqValid) && (!outValidReg || outReady);
  assign strobes.load = loadNow;
  assign strobes.sel  = winSel;
  assign ack          = loadNow ? winSel : '0;
  assign outValid     = outValidReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValidReg <= 1'b0;
    end else if (loadNow) begin
      outValidReg <= 1'b1;
    end else if (outReady) begin
      outValidReg <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_loss
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lossCnt[g] <= '0;
        end else if (!reqValid[g]) begin
          lossCnt[g] <= '0;
        end else if (loadNow) begin
          if (winSel[g]) begin
            lossCnt[g] <= '0;
          end else if (lossCnt[g] < CNT_W'(LIMIT)) begin
            lossCnt[g] <= lossCnt[g] + 1'b1;
          end
        end
      end

      // R3
      loss_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
        lossCnt[g] <= CNT_W'(LIMIT));

      // R4
      ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
        ack[g] |-> reqValid[g]);
    end
  endgenerate

  // R4
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ack));

  // R5
  stall_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> (ack == '0));

  // R9
  accept_sets_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ack) |=> outValid);

  // R2
  mc_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid[CH_MC] && loadNow && !starved[CH_DB] && !starved[CH_MV]) |-> ack[CH_MC]);
endmodule

// File: rtl/xl_xlate_dpath.sv
module xl_xlate_dpath
  import xl_pkg::*;
#(
  parameter int C_W = COL_W,
  parameter int B_W = BANK_W,
  parameter int R_W = ROW_W,
  parameter int M_W = MV_W,
  parameter int P_W = PIX_W,
  parameter int F_W = FRM_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xlStrobe_t                strobes,
  input  logic [P_W-1:0]           mcAddr,
  input  logic [F_W-1:0]           mcFrame,
  input  logic [P_W-1:0]           dbAddr,
  input  logic [F_W-1:0]           dbFrame,
  input  logic [M_W-1:0]           mvAddr,
  output logic [R_W+B_W+C_W:0]     outWord
);
  localparam int LIN_W  = R_W + B_W + C_W;
  localparam int WORD_W = LIN_W + 1;

  logic [LIN_W-1:0]  linMc;
  logic [LIN_W-1:0]  linDb;
  logic [LIN_W-1:0]  linMv;
  logic [LIN_W-1:0]  linSel;
  logic              wrSel;
  logic [WORD_W-1:0] nextWord;
  logic [WORD_W-1:0] wordReg;

  function automatic logic [LIN_W-1:0] pixLinear(input logic [F_W-1:0] frm,
                                                 input logic [P_W-1:0] adr);
    logic [LIN_W-1:0] partBase;
    partBase  = '0;
    partBase[M_W] = 1'b1;
    return partBase + LIN_W'({frm, adr});
  endfunction

  assign linMc = pixLinear(mcFrame, mcAddr);
  assign linDb = pixLinear(dbFrame, dbAddr);
  assign linMv = LIN_W'(mvAddr);

  always_comb begin
    linSel = linMv;
    wrSel  = 1'b0;
    if (strobes.sel[CH_MC]) begin
      linSel = linMc;
    end else if (strobes.sel[CH_DB]) begin
      linSel = linDb;
      wrSel  = 1'b1;
    end
  end

  assign nextWord = {wrSel,
                     linSel[C_W+B_W +: R_W],
                     linSel[C_W +: B_W],
                     linSel[C_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (strobes.load) begin
      wordReg <= nextWord;
    end
  end

  assign outWord = wordReg;

  // R6
  mv_partition_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.sel[CH_MV]) |=> (outWord[LIN_W-1:0] < (LIN_W+1)'(1 << M_W)));

  // R7
  pix_partition_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.sel[CH_MV]) |=> (outWord[LIN_W-1:0] >= (LIN_W+1)'(1 << M_W)));

  // R8
  write_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (outWord[LIN_W] == $past(strobes.sel[CH_DB])));
endmodule

// File: rtl/chan_addr_xlate.sv
module chan_addr_xlate
  import xl_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         mcValid,
  input  logic [PIX_W-1:0]             mcAddr,
  input  logic [FRM_W-1:0]             mcFrame,
  output logic                         mcAck,
  input  logic                         dbValid,
  input  logic [PIX_W-1:0]             dbAddr,
  input  logic [FRM_W-1:0]             dbFrame,
  output logic                         dbAck,
  input  logic                         mvValid,
  input  logic [MV_W-1:0]              mvAddr,
  output logic                         mvAck,
  output logic                         outValid,
  input  logic                         outReady,
  output logic [ROW_W+BANK_W+COL_W:0]  outWord
);
  xlStrobe_t         strobes;
  logic [NUM_CH-1:0] reqValid;
  logic [NUM_CH-1:0] ackVec;

  assign reqValid = {mvValid, dbValid, mcValid};
  assign mcAck    = ackVec[CH_MC];
  assign dbAck    = ackVec[CH_DB];
  assign mvAck    = ackVec[CH_MV];

  xl_arb_ctrl #(.LIMIT(STARVE_LIM)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .outReady (outReady),
    .strobes  (strobes),
    .ack      (ackVec),
    .outValid (outValid)
  );

  xl_xlate_dpath #(
    .C_W (COL_W),
    .B_W (BANK_W),
    .R_W (ROW_W),
    .M_W (MV_W),
    .P_W (PIX_W),
    .F_W (FRM_W)
  ) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .mcAddr  (mcAddr),
    .mcFrame (mcFrame),
    .dbAddr  (dbAddr),
    .dbFrame (dbFrame),
    .mvAddr  (mvAddr),
    .outWord (outWord)
  );

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));
endmodule

// File: tb/chan_addr_xlate_tb_top.sv
module chan_addr_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rv [3];
  logic [18:0] ra [3];
  logic [1:0]  rf [3];
  logic        outReady = 1'b0;
  logic        mcAck, dbAck, mvAck, outValid;
  logic [22:0] outWord;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  int          mCnt [3];
  logic        expValid = 1'b0;
  logic [22:0] expWord = '0;
  int          expCh = 0;
  logic [2:0]  lastAck = '0;

  always #10 clk = ~clk;

  chan_addr_xlate dut_i (
    .clk(clk), .rstN(rstN),
    .mcValid(rv[0]), .mcAddr(ra[0]), .mcFrame(rf[0]), .mcAck(mcAck),
    .dbValid(rv[1]), .dbAddr(ra[1]), .dbFrame(rf[1]), .dbAck(dbAck),
    .mvValid(rv[2]), .mvAddr(ra[2][15:0]), .mvAck(mvAck),
    .outValid(outValid), .outReady(outReady), .outWord(outWord)
  );

  function automatic logic [22:0] modelWord(int ch, logic [18:0] a, logic [1:0] f);
    logic [21:0] lin;
    if (ch == 2) lin = 22'(a[15:0]);
    else         lin = 22'h010000 + 22'(f) * 22'h080000 + 22'(a);
    return {(ch == 1) ? 1'b1 : 1'b0, lin};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [2:0] gotAck, expAck;
    logic anyV, mLoad, starvedWin;
    int win;
    string tag;
    @(negedge clk);
    anyV  = rv[0] | rv[1] | rv[2];
    mLoad = anyV && (!expValid || outReady);
    win = -1;
    starvedWin = 1'b0;
    for (int i = 2; i >= 0; i--)
      if (win < 0 && rv[i] && mCnt[i] >= 8) begin win = i; starvedWin = 1'b1; end
    for (int i = 0; i < 3; i++)
      if (win < 0 && rv[i]) win = i;
    expAck = '0;
    if (mLoad) expAck[win] = 1'b1;
    gotAck = {mvAck, dbAck, mcAck};
    tag = (expValid && !outReady) ? "R5" : (starvedWin ? "R3" : "R2");
    chk(gotAck == expAck, tag, 32'(gotAck), 32'(expAck));
    chk($countones(gotAck) <= 1, "R4", 32'(gotAck), 32'(expAck));
    chk(outValid == expValid, "R9", 32'(outValid), 32'(expValid));
    if (expValid) begin
      chk(outWord[22] == expWord[22], "R8", 32'(outWord), 32'(expWord));
      chk(outWord[21:0] == expWord[21:0], (expCh == 2) ? "R6" : "R7",
          32'(outWord), 32'(expWord));
    end
    // model update
    if (expValid && outReady) expValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (!rv[i]) mCnt[i] = 0;
      else if (mLoad) begin
        if (i == win) mCnt[i] = 0;
        else if (mCnt[i] < 8) mCnt[i]++;
      end
    end
    if (mLoad) begin
      expValid = 1'b1;
      expWord  = modelWord(win, ra[win], rf[win]);
      expCh    = win;
    end
    lastAck = expAck;
    @(posedge clk);
    #1;
  endtask

  // mode 0: drop acked, 1: re-arm mc only, 2: random traffic
  task automatic refill(int mode);
    for (int i = 0; i < 3; i++) begin
      if (lastAck[i]) begin
        if ((mode == 2 && ($urandom % 4) != 0) || (mode == 1 && i == 0)) begin
          rv[i] = 1'b1; ra[i] = 19'($urandom); rf[i] = 2'($urandom);
        end else begin
          rv[i] = 1'b0;
        end
      end else if (mode == 2 && !rv[i] && ($urandom % 3) == 0) begin
        rv[i] = 1'b1; ra[i] = 19'($urandom); rf[i] = 2'($urandom);
      end
    end
    if (mode == 2) outReady = (($urandom % 10) < 7);
  endtask

  task automatic setReq(int ch, logic [18:0] a, logic [1:0] f);
    rv[ch] = 1'b1; ra[ch] = a; rf[ch] = f;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin rv[i] = 1'b0; ra[i] = '0; rf[i] = '0; mCnt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1", 32'(outValid), 0);
    chk({mvAck, dbAck, mcAck} == 3'b000, "R1", 32'({mvAck, dbAck, mcAck}), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    outReady = 1'b1;
    step();
    chk(outValid == 1'b0, "R1", 32'(outValid), 0);

    // R6: motion-vector corners
    setReq(2, 19'h00000, 2'd0); step(); refill(0); step();
    setReq(2, 19'h0FFFF, 2'd0); step(); refill(0); step();
    // R7/R8: pixel corners, both pixel channels at once (R2 ordering)
    setReq(1, 19'h7FFFF, 2'd3);
    setReq(0, 19'h00000, 2'd0);
    step(); refill(0); step(); refill(0); step();
    // R2: all three together
    setReq(0, 19'h12345, 2'd1); setReq(1, 19'h00400, 2'd2); setReq(2, 19'h0ABCD, 2'd0);
    repeat (4) begin step(); refill(0); end
    step();
    // R5: stall with a full output register
    outReady = 1'b0;
    setReq(0, 19'h00101, 2'd2); setReq(1, 19'h3F0FF, 2'd1); setReq(2, 19'h00077, 2'd0);
    repeat (5) begin step(); refill(0); end
    outReady = 1'b1;
    repeat (5) begin step(); refill(0); end
    // R3: channel 0 keeps requesting, 1 and 2 starve
    setReq(0, 19'h00011, 2'd0); setReq(1, 19'h00022, 2'd1); setReq(2, 19'h00033, 2'd0);
    repeat (24) begin step(); refill(1); end
    rv[0] = 1'b0;
    repeat (4) begin step(); refill(0); end
    // random traffic
    repeat (3000) begin step(); refill(2); end
    outReady = 1'b1;
    for (int i = 0; i < 3; i++) rv[i] = 1'b0;
    repeat (3) step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule